// File: doc/BRIEF.md
# Search-Result Latency Pipeline

This block holds back the outcome of each table operation so that it reaches the pins a fixed, programmed number of clock cycles after the operation was issued. The total delay has two parts. The first is a base latency that the table-size setting selects. The second is an extra hit latency of zero to seven cycles, which applies only to the signals that carry search results and read acknowledges. Operations arrive on a per-cycle strobe that carries a two-bit kind, together with the raw hit bit from the search array. The block accepts one operation in every cycle.

Results leave on two lanes, and each lane has a fixed delay. The long lane carries the search result (found and valid) and the acknowledge for searches and SRAM reads; its delay is base plus extra. The short lane carries the acknowledge for learns and SRAM writes; its delay is the base alone. Because the delay within a lane never varies, results on a lane come out in issue order and never overlap. Results on different lanes may coincide in the same cycle.

The operation input has a valid strobe and no ready. The block never applies back-pressure, so an operation presented with `op_valid` high is always taken on that clock edge.

Top module: `search_latency_pipe`

## Requirements
- R1: The base latency follows `size_code`: 00 gives 4 cycles, 01 gives 5 and 10 gives 6. An operation sampled on clock edge k shows its short-lane result in the cycle after edge k+base-1.
- R2: The reserved `size_code` value 11 behaves exactly like 10, with a base of 6 cycles.
- R3: The value of `extra_lat` is added as a plain binary count of 0 to 7 cycles to the long lane. Searches and SRAM reads therefore come out after base plus `extra_lat` cycles.
- R4: A search (`op_kind` 00) gives a single-cycle pulse on `srch_valid` and on `long_ack`, and `srch_found` equals the raw hit bit sampled with the search. A miss gives valid 1 and found 0. `srch_found` is never high without `srch_valid`, and `srch_valid` is never high without `long_ack`.
- R5: An SRAM read (`op_kind` 10) pulses only `long_ack`. Its `srch_valid` and `srch_found` stay 0.
- R6: A learn (`op_kind` 01) or an SRAM write (`op_kind` 11) pulses only `short_ack`, after the base latency. `extra_lat` has no effect on these operations.
- R7: The block takes one operation per cycle with no stall. Operations issued back to back each produce exactly one pulse on their lane, in issue order.
- R8: While reset is held, all outputs are 0. For fewer cycles than the smallest base latency after reset is released, no output pulses.
- R9: While `op_valid` is low, no output pulse is produced, whatever the values of `op_kind` and `raw_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset that clears every stage |
| op_valid | input | 1 | An operation is issued in this cycle |
| op_kind | input | 2 | 00 search, 01 learn, 10 SRAM read, 11 SRAM write |
| raw_hit | input | 1 | Undelayed hit bit that goes with a search |
| size_code | input | 2 | Table-size setting that selects the base latency |
| extra_lat | input | 3 | Extra latency for search results and read acknowledges |
| srch_found | output | 1 | Delayed search hit flag |
| srch_valid | output | 1 | Delayed search-result strobe |
| long_ack | output | 1 | Delayed acknowledge for searches and reads |
| short_ack | output | 1 | Delayed acknowledge for learns and writes |

## Verification
The timing assertions assume that `size_code` and `extra_lat` stay constant from reset onward, because the block does not support a change of configuration while operations are in flight. The stimulus therefore writes a new configuration only while reset is held, and then sweeps all 32 combinations in turn. Each sweep mixes a run of back-to-back searches, random operation kinds and idle cycles in which `raw_hit` and `op_kind` keep toggling. The bench predicts every output arithmetically from the recorded issue cycle and the lane delay.

// File: rtl/rlat_pkg.sv
package rlat_pkg;
  typedef enum logic [1:0] {
    OP_SEARCH = 2'b00,
    OP_LEARN  = 2'b01,
    OP_RD     = 2'b10,
    OP_WR     = 2'b11
  } op_kind_e;
endpackage

// File: rtl/rlat_decode.sv
module rlat_decode #(
  parameter int BASE_LAT0 = 4,
  parameter int EXTRA_W   = 3,
  parameter int SEL_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         size_code,
  input  logic [EXTRA_W-1:0] extra_lat,
  output logic [SEL_W-1:0]   base_tap,
  output logic [SEL_W-1:0]   total_tap
);
  logic [1:0] step;

  // code 3 is reserved and folds onto the largest setting
  always_comb begin
    step = (size_code == 2'b11) ? 2'b10 : size_code;
    base_tap  = SEL_W'(BASE_LAT0) + SEL_W'(step);
    total_tap = base_tap + SEL_W'(extra_lat);
  end

  AST_BASE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tap >= SEL_W'(BASE_LAT0)) && (base_tap <= SEL_W'(BASE_LAT0 + 2))); // R1
  AST_RESERVED_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == 2'b11) |-> (base_tap == SEL_W'(BASE_LAT0 + 2))); // R2
endmodule

// File: rtl/rlat_delay_line.sv
module rlat_delay_line #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 13,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] tap,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [DEPTH];
  logic [SEL_W-1:0] idx;
  logic [WIDTH-1:0] pick [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign idx = tap - SEL_W'(1);

  // one-hot tap selection, ORed together
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign pick[g] = (idx == SEL_W'(g)) ? stg[g] : '0;
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++) dout = dout | pick[i];
  end

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap >= SEL_W'(1)) && (tap <= SEL_W'(DEPTH))); // R3
endmodule

// File: rtl/search_latency_pipe.sv
module search_latency_pipe #(
  parameter int BASE_LAT0 = 4,
  parameter int EXTRA_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic               raw_hit,
  input  logic [1:0]         size_code,
  input  logic [EXTRA_W-1:0] extra_lat,
  output logic               srch_found,
  output logic               srch_valid,
  output logic               long_ack,
  output logic               short_ack
);
  import rlat_pkg::*;

  localparam int MAX_BASE  = BASE_LAT0 + 2;
  localparam int MAX_TOTAL = MAX_BASE + (2 ** EXTRA_W) - 1;
  localparam int SEL_W     = $clog2(MAX_TOTAL + 1);

  logic [SEL_W-1:0] base_tap, total_tap;
  logic             is_srch, is_rd, is_short;
  logic [2:0]       long_din, long_dout;
  logic [0:0]       short_din, short_dout;

  assign is_srch  = op_valid && (op_kind == OP_SEARCH);
  assign is_rd    = op_valid && (op_kind == OP_RD);
  assign is_short = op_valid && ((op_kind == OP_LEARN) || (op_kind == OP_WR));

  assign long_din  = {is_srch & raw_hit, is_srch, is_srch | is_rd};
  assign short_din = is_short;

  rlat_decode #(.BASE_LAT0(BASE_LAT0), .EXTRA_W(EXTRA_W), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .size_code(size_code), .extra_lat(extra_lat),
    .base_tap(base_tap), .total_tap(total_tap)
  );

  rlat_delay_line #(.WIDTH(3), .DEPTH(MAX_TOTAL), .SEL_W(SEL_W)) u_long (
    .clk(clk), .rst_n(rst_n), .din(long_din), .tap(total_tap), .dout(long_dout)
  );

  rlat_delay_line #(.WIDTH(1), .DEPTH(MAX_BASE), .SEL_W(SEL_W)) u_short (
    .clk(clk), .rst_n(rst_n), .din(short_din), .tap(base_tap), .dout(short_dout)
  );

  assign srch_found = long_dout[2];
  assign srch_valid = long_dout[1];
  assign long_ack   = long_dout[0];
  assign short_ack  = short_dout[0];

  // edges since reset, saturating; feeds the timing checks below
  logic [SEL_W-1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != SEL_W'(MAX_TOTAL)) age <= age + SEL_W'(1);
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (age < SEL_W'(BASE_LAT0)) |-> !(srch_valid || long_ack || short_ack)); // R8
  AST_FOUND_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    srch_found |-> srch_valid); // R4
  AST_VALID_BRINGS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |-> long_ack); // R4
  AST_SEARCH_MIN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == 2'b00 && extra_lat == '0 && age >= SEL_W'(BASE_LAT0)) |->
      (srch_valid == $past(op_valid && op_kind == OP_SEARCH, 4))); // R3
  AST_SHORT_MIN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == 2'b00 && age >= SEL_W'(BASE_LAT0)) |->
      (short_ack == $past(op_valid && (op_kind == OP_LEARN || op_kind == OP_WR), 4))); // R6
endmodule

// File: tb/search_latency_pipe_test.sv
`timescale 1ns/1ps
module search_latency_pipe_test;
  localparam int NCYC = 70;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [1:0] op_kind;
  logic       raw_hit;
  logic [1:0] size_code;
  logic [2:0] extra_lat;
  logic       srch_found, srch_valid, long_ack, short_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic       ev_v [NCYC];
  logic [1:0] ev_k [NCYC];
  logic       ev_h [NCYC];
  logic [15:0] lfsr;

  always #2 clk = ~clk;

  search_latency_pipe uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .raw_hit(raw_hit), .size_code(size_code), .extra_lat(extra_lat),
    .srch_found(srch_found), .srch_valid(srch_valid),
    .long_ack(long_ack), .short_ack(short_ack)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (size=%0d extra=%0d)",
               req, what, act, exp, size_code, extra_lat);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'b00; raw_hit = 1'b0;
    size_code = 2'b00; extra_lat = 3'd0;
    for (int sc = 0; sc < 4; sc++) begin
      for (int ex = 0; ex < 8; ex++) begin
        int base, tot;
        rst_n = 1'b0; op_valid = 1'b0;
        size_code = 2'(sc); extra_lat = 3'(ex);
        lfsr = 16'hACE1 ^ 16'(sc * 97 + ex * 13 + 1);
        repeat (2) @(negedge clk);
        // R8: everything quiet while reset is held
        chk(srch_found, 1'b0, "R8", "found in reset");
        chk(srch_valid, 1'b0, "R8", "valid in reset");
        chk(long_ack,   1'b0, "R8", "long_ack in reset");
        chk(short_ack,  1'b0, "R8", "short_ack in reset");
        rst_n = 1'b1;
        base = (sc == 3) ? 6 : 4 + sc;
        tot  = base + ex;
        for (int c = 0; c < NCYC; c++) begin
          int jl, js;
          logic el, ev, ef, es;
          string rs;
          jl = c - tot; js = c - base;
          el = 1'b0; ev = 1'b0; ef = 1'b0; es = 1'b0;
          if (jl >= 0 && ev_v[jl]) begin
            el = (ev_k[jl] == 2'b00) || (ev_k[jl] == 2'b10);
            ev = (ev_k[jl] == 2'b00);
            ef = ev && ev_h[jl];
          end
          if (js >= 0 && ev_v[js])
            es = (ev_k[js] == 2'b01) || (ev_k[js] == 2'b11);
          rs = (sc == 3) ? "R2" : "R1/R6";
          // R3 long-lane timing, R4 search result, R5 read ack, R7 order, R9 idle
          chk(long_ack,   el, "R3/R5/R7", "long_ack");
          chk(srch_valid, ev, "R4/R9", "srch_valid");
          chk(srch_found, ef, "R4", "srch_found");
          chk(short_ack,  es, rs, "short_ack");
          // drive operation c
          step_lfsr();
          if (c < 8) begin
            // R7: back-to-back searches, hits alternating
            op_valid = 1'b1; op_kind = 2'b00; raw_hit = c[0];
          end else if (c < 50) begin
            op_valid = lfsr[0] | lfsr[1];
            op_kind  = lfsr[3:2];
            raw_hit  = lfsr[4];
          end else begin
            // R9: kind and hit toggle while op_valid is low
            op_valid = 1'b0; op_kind = lfsr[3:2]; raw_hit = lfsr[4];
          end
          ev_v[c] = op_valid; ev_k[c] = op_kind; ev_h[c] = raw_hit;
          @(negedge clk);
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule